// File: doc/BRIEF.md
# Center-Aligned Up/Down PWM Timer

This block is one timer channel that produces center-aligned pulse-width modulation. A counter climbs from zero to a programmable period value, turns, and descends back to zero, repeating without pause. One step is taken per prescaler tick, so a full cycle lasts twice the period value in ticks. A compare value sets the duty cycle. The output rises when the count meets the compare value on the way up and falls when it meets it again on the way down. The pulse is therefore centred on the turn at the period value.

Software-side writes to the period and compare values land in shadow registers. They are copied into the active registers only at the turn-around point that the update mode selects: at the top, at the bottom, or at both. The top copy in the both mode depends on a separate circular-buffer enable. While the channel is disabled, the shadows are copied every cycle so that a fresh configuration takes effect from the first step. Single-cycle pulses flag the top, the zero and the compare match. When the period is less than half of full scale, the compare MSB picks the ramp on which the match pulse fires.

Top module: `dspwm_center_timer`

## Requirements
- R1: With active period T (T >= 1), counting the enabled ticks from k = 1, `top_o` pulses after tick k when k mod 2T equals T, and `zero_o` pulses when k mod 2T equals 0. The counted value is k mod 2T while that is at most T, and 2T minus it otherwise.
- R2: Let C be the effective compare value, with 0 < C < T. `pwm_o` goes high when the count reaches C on a rising step and goes low when it reaches C on a falling step. Over one full cycle it is high for 2(T - C) ticks.
- R3: An effective compare value of 0 holds `pwm_o` high for the whole cycle. An effective compare value of T or more holds it low, with no edge at either turn-around.
- R4: All outputs are registered and change only on the clock edge of an enabled tick. Pulses last one cycle. Without a tick, `pwm_o` holds and the three pulse outputs are 0.
- R5: When T < 2^(CNT_W-1), the lower CNT_W-1 compare bits form the effective value. The compare MSB then picks the ramp for `match_o`: 0 selects rising steps (including arrival at T) and 1 selects falling steps (including arrival at 0). Otherwise all CNT_W bits form the value and `match_o` fires on either ramp. `match_o` pulses when the new count equals the effective value on the selected ramp.
- R6: While `en` is low the count is held at zero, and all four outputs are 0 from the next edge. After `en` rises, counting restarts on a rising ramp, so the first tick reaches 1.
- R7: `upd_mode` encodings are 0 = copy at top, 1 = copy at zero, and 2 or 3 = copy at zero and also at top when `circ_en` is 1. While enabled, a written value does not change the waveform before the selected copy point.
- R8: While `en` is low, the shadow values are copied into the active registers on every clock edge.
- R9: A period write with data 0 is discarded, and the previous shadow period is kept.
- R10: Reset sets all outputs to 0, the active period to `PER_RST` and the active compare to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable |
| tick | input | 1 | Prescaler tick; one counter step per high cycle |
| per_wr | input | 1 | Period shadow write strobe |
| per_wdata | input | CNT_W | Period value to write |
| cmp_wr | input | 1 | Compare shadow write strobe |
| cmp_wdata | input | CNT_W | Compare value to write (MSB is the ramp select for short periods) |
| upd_mode | input | 2 | Shadow copy point: 0 top, 1 zero, 2/3 both |
| circ_en | input | 1 | Allows the top copy in both mode |
| pwm_o | output | 1 | Center-aligned waveform |
| top_o | output | 1 | One-cycle pulse on reaching the period value |
| zero_o | output | 1 | One-cycle pulse on reaching zero |
| match_o | output | 1 | One-cycle pulse on compare match on the selected ramp |

## Verification
The assertions take for granted that the active period is never zero, and that the active period changes only at a turn-around, so a rising count can never sit above it. The block guarantees the first through the dropped zero writes and the copy points. The stimulus holds every input steady across each clock edge and changes it just after an edge. It configures period and compare while the channel is disabled, and it makes mid-run writes only at ticks whose copy point is known in advance. The pulse-exclusivity and spacing checks therefore assume the period is at least 1, which the dropped zero writes enforce.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;

  typedef enum logic [1:0] {
    UPD_AT_TOP    = 2'd0,
    UPD_AT_ZERO   = 2'd1,
    UPD_AT_BOTH   = 2'd2,
    UPD_AT_BOTH_B = 2'd3
  } upd_mode_e;

  // Copy point at the top turn-around is allowed for this mode
  function automatic logic top_copy_ok(upd_mode_e m, logic circ);
    return (m == UPD_AT_TOP) || (((m == UPD_AT_BOTH) || (m == UPD_AT_BOTH_B)) && circ);
  endfunction

  // Copy point at the zero turn-around is allowed for this mode
  function automatic logic zero_copy_ok(upd_mode_e m);
    return m != UPD_AT_TOP;
  endfunction

endpackage

// File: rtl/dspwm_shadow.sv
module dspwm_shadow #(
  parameter int unsigned W         = 16,
  parameter logic [W-1:0] RST_VAL  = '0,
  parameter bit          DROP_ZERO = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         load,
  output logic [W-1:0] active_q
);

  logic [W-1:0] shadow_q;
  logic         accept;

  generate
    if (DROP_ZERO) begin : g_drop
      assign accept = wr_en && (wr_data != '0);
    end else begin : g_keep
      assign accept = wr_en;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= RST_VAL;
      active_q <= RST_VAL;
    end else begin
      if (accept) shadow_q <= wr_data;
      if (load)   active_q <= shadow_q;
    end
  end

endmodule

// File: rtl/dspwm_updown.sv
module dspwm_updown #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] per,
  output logic         step_c,
  output logic [W-1:0] next_c,
  output logic         rising_c,
  output logic         hit_top_c,
  output logic         hit_zero_c
);

  logic [W-1:0] cnt_q;
  logic         up_q;
  logic [W:0]   inc;

  assign inc        = {1'b0, cnt_q} + (W+1)'(1);
  assign step_c     = en && tick;
  assign rising_c   = up_q;
  assign next_c     = up_q ? inc[W-1:0] : (cnt_q - W'(1));
  assign hit_top_c  = up_q && (inc >= {1'b0, per});
  assign hit_zero_c = !up_q && (next_c == '0);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (tick) begin
      cnt_q <= next_c;
      if (hit_top_c)  up_q <= 1'b0;
      if (hit_zero_c) up_q <= 1'b1;
    end
  end

endmodule

// File: rtl/dspwm_wavegen.sv
module dspwm_wavegen #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         step,
  input  logic [W-1:0] next_cnt,
  input  logic         rising,
  input  logic         hit_top,
  input  logic         hit_zero,
  input  logic [W-1:0] per,
  input  logic [W-1:0] cmp,
  output logic         pwm_q,
  output logic         top_q,
  output logic         zero_q,
  output logic         match_q
);

  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  logic         split;
  logic [W-1:0] eff;
  logic         ramp_ok;
  logic         match_c;
  logic         level_c;

  assign split   = per < HALF;
  assign eff     = split ? {1'b0, cmp[W-2:0]} : cmp;
  assign ramp_ok = !split || (cmp[W-1] != rising);
  assign match_c = (next_cnt == eff) && ramp_ok;

  always_comb begin
    if (eff == '0)       level_c = 1'b1;
    else if (eff >= per) level_c = 1'b0;
    else if (rising)     level_c = next_cnt >= eff;
    else                 level_c = next_cnt > eff;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pwm_q   <= 1'b0;
      top_q   <= 1'b0;
      zero_q  <= 1'b0;
      match_q <= 1'b0;
    end else if (step) begin
      pwm_q   <= level_c;
      top_q   <= hit_top;
      zero_q  <= hit_zero;
      match_q <= match_c;
    end else begin
      top_q   <= 1'b0;
      zero_q  <= 1'b0;
      match_q <= 1'b0;
    end
  end

endmodule

// File: rtl/dspwm_center_timer.sv
module dspwm_center_timer #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PER_RST = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             tick,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic [1:0]       upd_mode,
  input  logic             circ_en,
  output logic             pwm_o,
  output logic             top_o,
  output logic             zero_o,
  output logic             match_o
);
  import dspwm_pkg::*;

  localparam logic [CNT_W-1:0] PER_INIT = CNT_W'(PER_RST);

  logic [CNT_W-1:0] per_act, cmp_act, next_cnt;
  logic             step, rising, hit_top, hit_zero;
  logic             copy_now;
  upd_mode_e        mode;

  assign mode     = upd_mode_e'(upd_mode);
  assign copy_now = !en ||
                    (step && ((hit_top  && top_copy_ok(mode, circ_en)) ||
                              (hit_zero && zero_copy_ok(mode))));

  dspwm_shadow #(.W(CNT_W), .RST_VAL(PER_INIT), .DROP_ZERO(1'b1)) u_per (
    .clk(clk), .rst(rst), .wr_en(per_wr), .wr_data(per_wdata),
    .load(copy_now), .active_q(per_act)
  );

  dspwm_shadow #(.W(CNT_W), .RST_VAL('0), .DROP_ZERO(1'b0)) u_cmp (
    .clk(clk), .rst(rst), .wr_en(cmp_wr), .wr_data(cmp_wdata),
    .load(copy_now), .active_q(cmp_act)
  );

  dspwm_updown #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .per(per_act),
    .step_c(step), .next_c(next_cnt), .rising_c(rising),
    .hit_top_c(hit_top), .hit_zero_c(hit_zero)
  );

  dspwm_wavegen #(.W(CNT_W)) u_wave (
    .clk(clk), .rst(rst), .en(en), .step(step), .next_cnt(next_cnt),
    .rising(rising), .hit_top(hit_top), .hit_zero(hit_zero),
    .per(per_act), .cmp(cmp_act),
    .pwm_q(pwm_o), .top_q(top_o), .zero_q(zero_o), .match_q(match_o)
  );

endmodule

// File: rtl/dspwm_center_timer_chk.sv
module dspwm_center_timer_chk (
  input logic clk,
  input logic rst,
  input logic en,
  input logic tick,
  input logic pwm_o,
  input logic top_o,
  input logic zero_o,
  input logic match_o
);

  assert_top_zero_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
    !(top_o && zero_o));

  assert_top_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    top_o |=> !top_o);

  assert_pulse_needs_tick_R4: assert property (@(posedge clk) disable iff (rst)
    (top_o || zero_o || match_o) |-> $past(en && tick));

  assert_pwm_holds_R4: assert property (@(posedge clk) disable iff (rst)
    $past(en && !tick) |-> $stable(pwm_o));

  assert_quiet_disabled_R6: assert property (@(posedge clk) disable iff (rst)
    $past(!en) |-> (!pwm_o && !top_o && !zero_o && !match_o));

endmodule

bind dspwm_center_timer dspwm_center_timer_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .tick(tick),
  .pwm_o(pwm_o), .top_o(top_o), .zero_o(zero_o), .match_o(match_o)
);

// File: tb/tb_dspwm_center_timer.sv
module tb_dspwm_center_timer;
  localparam int W = 5;
  localparam int HALF = 16;

  logic clk = 0, rst = 1, en = 0, tick = 0;
  logic per_wr = 0, cmp_wr = 0, circ_en = 0;
  logic [W-1:0] per_wdata = '0, cmp_wdata = '0;
  logic [1:0] upd_mode = 2'd1;
  logic pwm_o, top_o, zero_o, match_o;

  int checks = 0, fails = 0;

  dspwm_center_timer #(.CNT_W(W), .PER_RST(6)) dut (
    .clk(clk), .rst(rst), .en(en), .tick(tick),
    .per_wr(per_wr), .per_wdata(per_wdata), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .upd_mode(upd_mode), .circ_en(circ_en),
    .pwm_o(pwm_o), .top_o(top_o), .zero_o(zero_o), .match_o(match_o)
  );

  always #2 clk = ~clk;

  task automatic chk(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
    end
  endtask

  task automatic step(bit t);
    tick = t;
    @(posedge clk); #1;
  endtask

  task automatic cfg(int T, int C);
    en = 0; tick = 0;
    per_wr = 1; per_wdata = W'(T);
    cmp_wr = 1; cmp_wdata = W'(C);
    @(posedge clk); #1;
    per_wr = 0; cmp_wr = 0;
    @(posedge clk); #1;
    en = 1;
  endtask

  // Expected outputs after enabled tick k, computed from the requirements
  function automatic void model(int k, int T, int C, output int e_top, output int e_zero,
                                output int e_match, output int e_pwm);
    int p, c, eff; bit up, split;
    p = k % (2*T);
    c = (p <= T) ? p : 2*T - p;
    up = (p >= 1) && (p <= T);
    split = T < HALF;
    eff = split ? C % HALF : C;
    e_top = (p == T);
    e_zero = (p == 0);
    e_match = (c == eff) && (!split || ((C / HALF) == 1 ? !up : up));
    if (eff == 0) e_pwm = 1;
    else if (eff >= T) e_pwm = 0;
    else e_pwm = up ? (c >= eff) : (c > eff);
  endfunction

  task automatic run_check(int T, int C, int n);
    int et, ez, em, ep, highs, eff;
    highs = 0;
    eff = (T < HALF) ? C % HALF : C;
    for (int k = 1; k <= n; k++) begin
      step(1);
      model(k, T, C, et, ez, em, ep);
      chk("R1", "top", top_o, et);
      chk("R1", "zero", zero_o, ez);
      chk("R5", "match", match_o, em);
      if (eff == 0 || eff >= T) chk("R3", "pwm clamp", pwm_o, ep);
      else chk("R2", "pwm", pwm_o, ep);
      if (k <= 2*T) highs += pwm_o;
    end
    chk("R2", "high ticks", highs, (eff >= T) ? 0 : 2*(T - eff));
  endtask

  initial begin
    #(4*190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int tlist[8] = '{1, 2, 3, 7, 15, 16, 17, 31};
    repeat (3) @(posedge clk);
    #1 rst = 0;
    chk("R10", "reset outs", {pwm_o, top_o, zero_o, match_o}, 0);

    // R10: reset period 6, compare 0
    en = 1;
    for (int k = 1; k <= 12; k++) begin
      step(1);
      chk("R10", "reset period top", top_o, (k % 12) == 6);
      chk("R10", "reset compare pwm", pwm_o, 1);
    end

    // Sweep R1 R2 R3 R5
    foreach (tlist[i]) begin
      for (int c = 0; c < 32; c++) begin
        cfg(tlist[i], c);
        run_check(tlist[i], c, 4*tlist[i]);
      end
    end

    // R4: prescaled ticks
    cfg(3, 1);
    for (int k = 1; k <= 12; k++) begin
      int et, ez, em, ep; logic prev;
      step(1);
      model(k, 3, 1, et, ez, em, ep);
      chk("R4", "tick top", top_o, et);
      chk("R4", "tick pwm", pwm_o, ep);
      prev = pwm_o;
      for (int j = 0; j < 2; j++) begin
        step(0);
        chk("R4", "idle pulses", {top_o, zero_o, match_o}, 0);
        chk("R4", "idle pwm hold", pwm_o, prev);
      end
    end

    // R6: disable and restart
    cfg(5, 0);
    for (int k = 1; k <= 3; k++) step(1);
    en = 0;
    for (int k = 0; k < 3; k++) begin
      step(1);
      chk("R6", "disabled outs", {pwm_o, top_o, zero_o, match_o}, 0);
    end
    en = 1;
    run_check(5, 0, 10);
    cfg(5, 3);
    for (int k = 1; k <= 4; k++) step(1);
    en = 0; step(0); en = 1;
    run_check(5, 3, 20);

    // R9: period zero write dropped; R8 copy while disabled
    cfg(3, 1);
    en = 0;
    per_wr = 1; per_wdata = '0;
    step(0);
    per_wr = 0;
    step(0); step(0);
    en = 1;
    run_check(3, 1, 12);

    // R7: compare update point by mode
    for (int m = 0; m < 5; m++) begin
      bit top_like;
      upd_mode = (m == 4) ? 2'd3 : ((m == 3) ? 2'd2 : 2'(m));
      circ_en = (m == 2) || (m == 4);
      top_like = (m == 0) || (m == 2) || (m == 4);
      cfg(4, 1);
      for (int k = 1; k <= 11; k++) begin
        if (k == 1) begin cmp_wr = 1; cmp_wdata = 5'd3; end
        step(1);
        cmp_wr = 0;
        if (k == 4) chk("R7", "cmp pwm at top", pwm_o, 1);
        if (k == 6) chk("R7", "cmp copy point", pwm_o, top_like ? 0 : 1);
        if (k == 10) chk("R7", "new cmp low", pwm_o, 0);
        if (k == 11) chk("R7", "new cmp high", pwm_o, 1);
      end
    end

    // R7: period update point, written after the top
    for (int m = 0; m < 2; m++) begin
      upd_mode = 2'(m);
      circ_en = 0;
      cfg(4, 0);
      for (int k = 1; k <= 14; k++) begin
        if (k == 5) begin per_wr = 1; per_wdata = 5'd6; end
        step(1);
        per_wr = 0;
        if (k == 12) chk("R7", "per top@12", top_o, m == 0);
        if (k == 14) chk("R7", "per top@14", top_o, m == 1);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule